// File: doc/BRIEF.md
# External Pin Interrupt Front End

This block watches 24 external interrupt pins and turns activity on them into interrupt requests for a main interrupt controller. Each pin passes through a two-flop synchroniser and is then qualified by its own 3-bit trigger mode: low level, high level, falling edge, rising edge or both edges. A pin takes part only when its 2-bit pin-function field selects the interrupt function. The four lowest pins are passed straight through to the main controller as their own sources.

The remaining twenty pins latch into an extended pending register, cleared by writing ones. An extended mask register, where 1 means masked, gates them onto two parent lines: one for pins 4 to 7 and one for pins 8 to 23. A parent line stays high while any unmasked pending bit in its group remains. A wake-enable register, limited by a fixed set of wake-capable pins (4 to 15), produces a wake request from pending pins. Software configures the block through a small write port that selects one of three trigger-mode banks, the mask, the pending-clear strobe or the wake enable.

Top module: `eint_frontend`

## Requirements
- R1: After reset, extended pending is 0, the extended mask reads 24'hFFFFF0 (bits 4 to 23 masked, bits 0 to 3 read 0), all trigger modes are 000, wake enable is 0, and direct_o, both parent lines and wake_o are 0.
- R2: A pin produces no event unless its function field pin_func_i[2k+1:2k] equals 2'b10; activity on a pin in any other function leaves pending and direct_o unchanged.
- R3: Pin inputs pass two synchroniser flops: an event derived from a pin change appears on direct_o two clock edges after the change, and an extended pending bit sets on the third edge.
- R4: Pin k's mode is bits [4j+2:4j] of bank k/8 (j = k mod 8), written with wr_sel_i = 0, 1, 2; encoding 000 low level, 001 high level, 01x falling edge, 10x rising edge, 11x both edges.
- R5: In a level mode the event holds for as long as the synchronised level holds, and a pending bit whose event is present in the same cycle as its clear stays set.
- R6: In an edge mode each qualifying transition gives one event lasting one cycle; transitions of the other direction give none.
- R7: Pins 0 to 3 drive direct_o[3:0] with their events and never set extended pending; ext_pend_o[3:0] always reads 0.
- R8: Writing wr_sel_i = 4 clears each extended pending bit whose data bit is 1; bits written 0 are unchanged.
- R9: The mask (wr_sel_i = 3, 1 = masked) does not stop pending bits from latching; it only removes them from the parent lines.
- R10: grp_lo_o is the OR of unmasked pending bits 4 to 7 and grp_hi_o of bits 8 to 23; a parent stays high until every unmasked pending bit of its group is cleared or masked.
- R11: wake_o is high when a pending bit in the wake-capable set (bits 4 to 15) has its wake enable bit set (wr_sel_i = 5); pending bits outside that set never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pins_i | input | 24 | Asynchronous external interrupt pins |
| pin_func_i | input | 48 | 2-bit function field per pin; 2'b10 selects interrupt |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Target: 0..2 mode banks, 3 mask, 4 pending clear, 5 wake enable |
| wr_data_i | input | 32 | Write data |
| direct_o | output | 4 | Events of pins 0 to 3 to the main controller |
| grp_lo_o | output | 1 | Parent line for pins 4 to 7 |
| grp_hi_o | output | 1 | Parent line for pins 8 to 23 |
| ext_pend_o | output | 24 | Extended pending register |
| ext_mask_o | output | 24 | Extended mask register |
| wake_o | output | 1 | Wake request |

## Verification
Each of the five trigger modes is driven on a direct pin with both rising and falling transitions, so an edge mode that fires on the wrong direction, a both-edge mode that misses one, or a level mode that fails to follow the pin shows up on direct_o. Extended pins are raised one at a time, in pairs inside one group, and across groups, with mask and clear writes in between, which separates latching from masking and shows whether a parent drops early while another bit of its group is pending. Held levels against clear writes distinguish set-wins ordering, and pending bits inside and outside the wake-capable range, with wake enable on and off, pin down the wake filter.

// File: rtl/eint_pkg.sv
package eint_pkg;
  localparam int MODE_W = 3;
  localparam int FIELD_STRIDE = 4;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_MASK = 3'd3;
  localparam logic [SEL_W-1:0] SEL_CLR  = 3'd4;
  localparam logic [SEL_W-1:0] SEL_WAKE = 3'd5;
  localparam logic [1:0] FUNC_EINT = 2'b10;

  function automatic logic mode_hit(logic [MODE_W-1:0] mode, logic cur, logic prev);
    logic hit;
    case (mode[2:1])
      2'b00:   hit = mode[0] ? cur : ~cur;
      2'b01:   hit = prev & ~cur;
      2'b10:   hit = ~prev & cur;
      default: hit = prev ^ cur;
    endcase
    return hit;
  endfunction
endpackage

// File: rtl/eint_pin_det.sv
module eint_pin_det
  import eint_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [1:0]        func_i,
  output logic              evt_o
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign evt_o = (func_i == FUNC_EINT) && mode_hit(mode_i, s2_q, prev_q);

  // a rising-only event can never repeat on the next cycle
  p_rise_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && mode_i[2:1] == 2'b10) |=> !(evt_o && mode_i[2:1] == 2'b10));
endmodule

// File: rtl/eint_regs.sv
module eint_regs
  import eint_pkg::*;
#(
  parameter int N_PINS   = 24,
  parameter int N_DIRECT = 4,
  parameter int CFG_W    = 32,
  parameter int N_BANKS  = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [SEL_W-1:0]         wr_sel_i,
  input  logic [CFG_W-1:0]         wr_data_i,
  input  logic [N_PINS-1:0]        evt_i,
  output logic [N_BANKS*CFG_W-1:0] cfg_o,
  output logic [N_PINS-1:0]        mask_o,
  output logic [N_PINS-1:0]        pend_o,
  output logic [N_PINS-1:0]        wake_en_o
);
  localparam logic [N_PINS-1:0] EXT_BITS = {{(N_PINS-N_DIRECT){1'b1}}, {N_DIRECT{1'b0}}};

  logic [CFG_W-1:0]  cfg_q [N_BANKS];
  logic [N_PINS-1:0] mask_q, pend_q, wake_q, clr_mask;

  assign clr_mask = (wr_en_i && wr_sel_i == SEL_CLR) ? wr_data_i[N_PINS-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < N_BANKS; b++) cfg_q[b] <= '0;
      mask_q <= EXT_BITS;
      pend_q <= '0;
      wake_q <= '0;
    end else begin
      for (int b = 0; b < N_BANKS; b++)
        if (wr_en_i && wr_sel_i == SEL_W'(b)) cfg_q[b] <= wr_data_i;
      if (wr_en_i && wr_sel_i == SEL_MASK) mask_q <= wr_data_i[N_PINS-1:0] & EXT_BITS;
      if (wr_en_i && wr_sel_i == SEL_WAKE) wake_q <= wr_data_i[N_PINS-1:0];
      // a present event wins over a clear in the same cycle
      pend_q <= ((pend_q & ~clr_mask) | evt_i) & EXT_BITS;
    end
  end

  for (genvar b = 0; b < N_BANKS; b++) begin : g_cfg
    assign cfg_o[b*CFG_W +: CFG_W] = cfg_q[b];
  end

  assign mask_o    = mask_q;
  assign pend_o    = pend_q;
  assign wake_en_o = wake_q;

  p_latch_despite_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_i & EXT_BITS) != '0) |=> ((pend_q & $past(evt_i & EXT_BITS)) == $past(evt_i & EXT_BITS)));

  p_clear_takes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_CLR) |=> ((pend_q & $past(clr_mask & ~evt_i)) == '0));

  p_pend_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(wr_en_i && wr_sel_i == SEL_CLR)) |=> (($past(pend_q) & ~pend_q) == '0));
endmodule

// File: rtl/eint_frontend.sv
module eint_frontend
  import eint_pkg::*;
#(
  parameter int N_PINS        = 24,
  parameter int N_DIRECT      = 4,
  parameter int GRP_SPLIT     = 8,
  parameter int PINS_PER_BANK = 8,
  parameter logic [N_PINS-1:0] WAKE_ALLOW = 24'h00FFF0,
  localparam int CFG_W   = PINS_PER_BANK * FIELD_STRIDE,
  localparam int N_BANKS = (N_PINS + PINS_PER_BANK - 1) / PINS_PER_BANK
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_PINS-1:0]   pins_i,
  input  logic [2*N_PINS-1:0] pin_func_i,
  input  logic                wr_en_i,
  input  logic [SEL_W-1:0]    wr_sel_i,
  input  logic [CFG_W-1:0]    wr_data_i,
  output logic [N_DIRECT-1:0] direct_o,
  output logic                grp_lo_o,
  output logic                grp_hi_o,
  output logic [N_PINS-1:0]   ext_pend_o,
  output logic [N_PINS-1:0]   ext_mask_o,
  output logic                wake_o
);
  logic [N_BANKS*CFG_W-1:0] cfg_flat;
  logic [N_PINS-1:0]        evt, pend, mask, wake_en, live;
  logic                     cfg_unused;

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    localparam int BASE = (p / PINS_PER_BANK) * CFG_W + (p % PINS_PER_BANK) * FIELD_STRIDE;
    eint_pin_det u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pins_i[p]),
      .mode_i (cfg_flat[BASE +: MODE_W]),
      .func_i (pin_func_i[2*p +: 2]),
      .evt_o  (evt[p])
    );
  end

  eint_regs #(
    .N_PINS   (N_PINS),
    .N_DIRECT (N_DIRECT),
    .CFG_W    (CFG_W),
    .N_BANKS  (N_BANKS)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .evt_i     (evt),
    .cfg_o     (cfg_flat),
    .mask_o    (mask),
    .pend_o    (pend),
    .wake_en_o (wake_en)
  );

  assign cfg_unused = ^cfg_flat;
  assign live       = pend & ~mask;
  assign direct_o   = evt[N_DIRECT-1:0];
  assign grp_lo_o   = |live[GRP_SPLIT-1:N_DIRECT];
  assign grp_hi_o   = |live[N_PINS-1:GRP_SPLIT];
  assign ext_pend_o = pend;
  assign ext_mask_o = mask;
  assign wake_o     = |(pend & wake_en & WAKE_ALLOW);

  p_wake_source_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> ((ext_pend_o & WAKE_ALLOW) != '0));

  p_parent_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_hi_o && !(wr_en_i && (wr_sel_i == SEL_CLR || wr_sel_i == SEL_MASK))) |=> grp_hi_o);
endmodule

// File: tb/eint_frontend_test.sv
`timescale 1ns/1ps
module eint_frontend_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [23:0] pins_i = '0;
  logic [47:0] pin_func_i = '0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_sel_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [3:0]  direct_o;
  logic        grp_lo_o, grp_hi_o, wake_o;
  logic [23:0] ext_pend_o, ext_mask_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] cfg_sh [3];

  eint_frontend uut (.*);

  always #4 clk_i = ~clk_i;

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [31:0] data);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
    step(1);
    wr_en_i = 1'b0;
  endtask

  task automatic set_mode(int pin, logic [2:0] mode);
    cfg_sh[pin/8][4*(pin%8) +: 3] = mode;
    wr(3'(pin/8), cfg_sh[pin/8]);
  endtask

  task automatic t_reset();
    chk("R1 pend", 32'(ext_pend_o), 0);
    chk("R1 mask", 32'(ext_mask_o), 32'hFFFFF0);
    chk("R1 outs", {grp_lo_o, grp_hi_o, wake_o, direct_o}, 0);
  endtask

  task automatic t_func_gate();
    // default mode 000 (low level) on all pins, but function fields are 00
    step(5);
    chk("R2 no pend while not interrupt func", 32'(ext_pend_o), 0);
    chk("R2 no direct while not interrupt func", 32'(direct_o), 0);
    for (int b = 0; b < 3; b++) begin
      cfg_sh[b] = 32'h44444444;
      wr(3'(b), cfg_sh[b]);
    end
    pin_func_i = {24{2'b10}};
    pin_func_i[25:24] = 2'b11;
    step(3);
    chk("R2 rise mode idle", 32'(ext_pend_o), 0);
    pins_i[12] = 1'b1;
    step(3);
    chk("R2 pin12 func 11 ignored", 32'(ext_pend_o[12]), 0);
    pin_func_i[25:24] = 2'b10;
    step(2);
    chk("R2 enabling while high gives no edge", 32'(ext_pend_o[12]), 0);
    pins_i[12] = 1'b0;
    step(3);
  endtask

  task automatic t_latency();
    pins_i[0] = 1'b1;
    pins_i[8] = 1'b1;
    step(2);
    chk("R3 direct after two edges", 32'(direct_o), 32'h1);
    chk("R3 pend not yet", 32'(ext_pend_o[8]), 0);
    step(1);
    chk("R3 direct pulse ends", 32'(direct_o), 0);
    chk("R3 pend on third edge", 32'(ext_pend_o[8]), 1);
    pins_i[0] = 1'b0;
    pins_i[8] = 1'b0;
    step(3);
    chk("R6 rise mode ignores fall", 32'(direct_o), 0);
    wr(3'd4, 32'h100);
    chk("R8 clear pin8", 32'(ext_pend_o), 0);
  endtask

  task automatic t_modes();
    set_mode(1, 3'b011);
    pins_i[1] = 1'b1;
    step(3);
    chk("R6 fall mode ignores rise", 32'(direct_o), 0);
    pins_i[1] = 1'b0;
    step(2);
    chk("R4 fall mode fires", 32'(direct_o), 32'h2);
    step(1);
    chk("R6 fall single cycle", 32'(direct_o), 0);
    set_mode(2, 3'b111);
    pins_i[2] = 1'b1;
    step(2);
    chk("R4 both mode rise", 32'(direct_o), 32'h4);
    step(1);
    chk("R6 both mode single", 32'(direct_o), 0);
    pins_i[2] = 1'b0;
    step(2);
    chk("R4 both mode fall", 32'(direct_o), 32'h4);
    step(1);
    chk("R6 both mode fall single", 32'(direct_o), 0);
    set_mode(3, 3'b001);
    pins_i[3] = 1'b1;
    step(2);
    chk("R4 high level", 32'(direct_o), 32'h8);
    step(4);
    chk("R5 high level holds", 32'(direct_o), 32'h8);
    pins_i[3] = 1'b0;
    step(2);
    chk("R5 high level drops", 32'(direct_o), 0);
    set_mode(0, 3'b000);
    chk("R4 low level on idle pin", 32'(direct_o), 32'h1);
    set_mode(0, 3'b101);
    chk("R4 rise mode x=1", 32'(direct_o), 0);
    set_mode(1, 3'b100);
    set_mode(2, 3'b100);
    set_mode(3, 3'b100);
    pins_i[1] = 1'b1;
    step(2);
    chk("R7 direct pin pulses", 32'(direct_o), 32'h2);
    step(2);
    chk("R7 direct pins never pend", 32'(ext_pend_o[3:0]), 0);
    pins_i[1] = 1'b0;
    step(3);
  endtask

  task automatic t_groups();
    pins_i[5] = 1'b1;
    step(3);
    chk("R9 latch while masked", 32'(ext_pend_o[5]), 1);
    chk("R9 masked parent low", 32'(grp_lo_o), 0);
    wr(3'd3, 32'h0);
    chk("R9 mask readback", 32'(ext_mask_o), 0);
    chk("R10 lo parent up", {grp_lo_o, grp_hi_o}, 32'h2);
    pins_i[9] = 1'b1;
    pins_i[20] = 1'b1;
    step(3);
    chk("R10 hi parent up", {grp_lo_o, grp_hi_o}, 32'h3);
    wr(3'd4, 32'h200);
    chk("R8 clear bit9 only", 32'(ext_pend_o), 32'h100020);
    chk("R10 hi parent held by pin20", 32'(grp_hi_o), 1);
    wr(3'd3, 32'h100000);
    chk("R10 hi parent drops when masked", {grp_lo_o, grp_hi_o}, 32'h2);
    wr(3'd4, 32'h0);
    chk("R8 zero write no effect", 32'(ext_pend_o), 32'h100020);
    wr(3'd4, 32'h000020);
    chk("R10 lo parent drops", 32'(grp_lo_o), 0);
    wr(3'd3, 32'h0);
    chk("R10 unmask restores hi", 32'(grp_hi_o), 1);
    pins_i = '0;
    wr(3'd4, 32'hFFFFFF);
    step(3);
    chk("R10 all cleared", {grp_lo_o, grp_hi_o, 24'(ext_pend_o)}, 0);
  endtask

  task automatic t_level_pend();
    set_mode(6, 3'b001);
    pins_i[6] = 1'b1;
    step(3);
    chk("R5 level pending", 32'(ext_pend_o[6]), 1);
    wr(3'd4, 32'h40);
    chk("R5 set beats clear", 32'(ext_pend_o[6]), 1);
    pins_i[6] = 1'b0;
    step(3);
    wr(3'd4, 32'h40);
    chk("R5 clear after level gone", 32'(ext_pend_o[6]), 0);
    set_mode(6, 3'b100);
    set_mode(7, 3'b000);
    step(1);
    chk("R4 ext low level", 32'(ext_pend_o[7]), 1);
    set_mode(7, 3'b100);
    wr(3'd4, 32'h80);
    chk("R8 clear pin7", 32'(ext_pend_o), 0);
  endtask

  task automatic t_wake();
    wr(3'd5, 32'hFFFFFF);
    chk("R11 idle", 32'(wake_o), 0);
    pins_i[20] = 1'b1;
    step(3);
    chk("R11 pin20 not wake capable", 32'(wake_o), 0);
    pins_i[15] = 1'b1;
    step(3);
    chk("R11 pin15 wakes", 32'(wake_o), 1);
    wr(3'd4, 32'h8000);
    chk("R11 drop after clear", 32'(wake_o), 0);
    wr(3'd5, 32'h0);
    pins_i[10] = 1'b1;
    step(3);
    chk("R11 disabled pin10", {wake_o, ext_pend_o[10]}, 32'h1);
    wr(3'd5, 32'h000400);
    chk("R11 enable pin10", 32'(wake_o), 1);
    pins_i = '0;
    wr(3'd4, 32'hFFFFFF);
    chk("R11 cleared", 32'(wake_o), 0);
  endtask

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(1);
    t_reset();
    t_func_gate();
    t_latency();
    t_modes();
    t_groups();
    t_level_pend();
    t_wake();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule